// File: doc/BRIEF.md
# Three-Group Supply Rail Sequencer

This block brings a board's supply rails up and down in a fixed group order. The rails are split into three groups. The block drives one enable per group. For each group it reads two digital flags from external threshold comparators: one says the group is above ninety percent of its nominal level, the other says it is below ten percent. When the on-request is raised, the groups are enabled lowest first. Each further group is enabled only once the previous group reports that it is up. When the request drops, the groups are released highest first. Each lower group is released only once the group above it has drained.

Several such sequencers share one open-drain fault wire. The block pulls that wire low when a group misses its rise or fall deadline. It also treats a low level on the wire, when it is not the one pulling, as a fault raised by another device. Any fault takes the rails down in the normal descending order. The block then waits a retry delay and a released wire before it tries again. A sticky register keeps the group and the kind of the last fault until it is cleared.

Top module: `railseq_top`

## Requirements
- R1: While reset is held and on the first cycle after it, all three enables are 0, powerGood is 0, faultPullDown is 0 and causeValid is 0.
- R2: From the off state with onReq high and faultLineIn high, group 1 is enabled one cycle later. Group k+1 is enabled in the cycle after a cycle in which group k's enable was set and grpHigh[k] was sampled high. powerGood is 1 while all three groups are enabled and up.
- R3: When onReq is sampled low with all groups up, group 3 is released on the next cycle. Group k-1 is released in the cycle after grpLow of group k is sampled high. The block is back in the off state the cycle after grpLow of group 1 is sampled high.
- R4: If onReq is sampled low while the block waits for group k to rise, group k and all groups above it are released on the next cycle, and the descent continues from group k with no fault recorded.
- R5: If a rising group is not high by the time TIMEOUT_CYC cycles have passed in its step, then on the next cycle three things happen. The cause register holds that group with kind 1 (rise timeout). faultPullDown goes high for exactly RETRY_CYC cycles. The descent starts from that group.
- R6: If a draining group is not low by the time TIMEOUT_CYC cycles have passed in its step, the cause register records that group with kind 2 (fall timeout) and faultPullDown goes high for RETRY_CYC cycles. The descent still moves on to the next lower group.
- R7: A low faultLineIn in any active step, with no fault already pending, records the current group with kind 3 (external), does not raise faultPullDown, and starts the descent from the current group.
- R8: After a faulted descent ends, all enables stay 0 until both conditions hold: at least RETRY_CYC cycles have passed and faultLineIn is sampled high. The block then restarts at group 1 if onReq is high, and goes to off otherwise.
- R9: In the off state a low faultLineIn holds all enables at 0 even with onReq high.
- R10: The cause register (causeValid, causeGroup 1..3, causeKind 1..3) keeps its value across descents and retries. It is zeroed one cycle after causeClear is sampled high. A fault recorded in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| onReq | input | 1 | Request to power the rails |
| grpHigh | input | 3 | Per group: above 90 % of nominal |
| grpLow | input | 3 | Per group: below 10 % of nominal |
| faultLineIn | input | 1 | Sensed level of shared fault wire (low = fault) |
| causeClear | input | 1 | Zeroes the fault-cause register |
| grpEnable | output | 3 | Per-group enables, bit 0 = group 1 |
| powerGood | output | 1 | All groups up |
| faultPullDown | output | 1 | 1 = pull the shared fault wire low |
| causeValid | output | 1 | A fault cause is held |
| causeGroup | output | 2 | Group (1..3) of the last fault |
| causeKind | output | 2 | 1 rise timeout, 2 fall timeout, 3 external |

## Verification
Every output is one register stage behind the inputs that move it. An enable, powerGood, the pull-down or the cause fields change at the first clock edge that samples the deciding comparator flag, request or fault-wire level, and they are visible from that edge on. Timeouts fire on the edge where a step has lasted TIMEOUT_CYC cycles. The retry follows the edge on which RETRY_CYC cycles have passed in the wait and the wire reads high. The bench drives inputs at the falling edge and steps a behavioural level-and-direction model at the rising edge. It compares all outputs at the next falling edge, so each expected value is checked in exactly the cycle it is due.

// File: rtl/railseq_pkg.sv
package railseq_pkg;

  localparam int NUM_GROUPS = 3;

  localparam logic [1:0] KIND_RISE = 2'd1;
  localparam logic [1:0] KIND_FALL = 2'd2;
  localparam logic [1:0] KIND_EXT  = 2'd3;

  typedef enum logic [3:0] {
    ST_OFF, ST_UP1, ST_UP2, ST_UP3, ST_ON,
    ST_DN3, ST_DN2, ST_DN1, ST_FWAIT
  } seqState_t;

  typedef struct packed {
    logic       clrTimer;
    logic       startPull;
    logic       record;
    logic [1:0] recGroup;
    logic [1:0] recKind;
  } ctrlStrobe_t;

  // index (0..2) of the group watched in a step
  function automatic logic [1:0] watchIdx(seqState_t s);
    case (s)
      ST_UP2, ST_DN2: return 2'd1;
      ST_UP3, ST_DN3, ST_ON: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [NUM_GROUPS-1:0] enableMask(seqState_t s);
    case (s)
      ST_UP1, ST_DN2: return 3'b001;
      ST_UP2, ST_DN3: return 3'b011;
      ST_UP3, ST_ON:  return 3'b111;
      default:        return 3'b000;
    endcase
  endfunction

  function automatic seqState_t downOf(seqState_t s);
    case (s)
      ST_UP1:  return ST_DN1;
      ST_UP2:  return ST_DN2;
      default: return ST_DN3;
    endcase
  endfunction

  function automatic seqState_t riseNext(seqState_t s);
    case (s)
      ST_UP1:  return ST_UP2;
      ST_UP2:  return ST_UP3;
      default: return ST_ON;
    endcase
  endfunction

  function automatic seqState_t fallNext(seqState_t s);
    case (s)
      ST_DN3:  return ST_DN2;
      default: return ST_DN1;
    endcase
  endfunction

  function automatic logic pickBit(logic [NUM_GROUPS-1:0] v, logic [1:0] i);
    case (i)
      2'd0:    return v[0];
      2'd1:    return v[1];
      default: return v[2];
    endcase
  endfunction

endpackage

// File: rtl/railseq_ctrl.sv
module railseq_ctrl
  import railseq_pkg::*;
#(
  parameter int TIMEOUT_CYC = 40,
  parameter int RETRY_CYC   = 30,
  parameter int TIMER_W     = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  onReq,
  input  logic [NUM_GROUPS-1:0] grpHigh,
  input  logic [NUM_GROUPS-1:0] grpLow,
  input  logic                  faultLineIn,
  input  logic [TIMER_W-1:0]    timer,
  output ctrlStrobe_t           strobe,
  output seqState_t             state,
  output logic [NUM_GROUPS-1:0] grpEnable,
  output logic                  powerGood
);

  seqState_t  nextState;
  logic       pending;
  logic       setPend;
  logic       clrPend;
  logic       timeUp;
  logic       retryDone;
  logic [1:0] wIdx;
  logic [1:0] wGroup;
  logic       wHigh;
  logic       wLow;

  assign timeUp    = timer >= TIMER_W'(TIMEOUT_CYC);
  assign retryDone = timer >= TIMER_W'(RETRY_CYC);
  assign wIdx      = watchIdx(state);
  assign wGroup    = wIdx + 2'd1;
  assign wHigh     = pickBit(grpHigh, wIdx);
  assign wLow      = pickBit(grpLow, wIdx);

  always_comb begin
    nextState = state;
    strobe    = '0;
    setPend   = 1'b0;
    clrPend   = 1'b0;
    unique case (state)
      ST_OFF: begin
        if (onReq && faultLineIn) nextState = ST_UP1;
      end
      ST_UP1, ST_UP2, ST_UP3: begin
        if (timeUp && !wHigh) begin
          strobe.record    = 1'b1;
          strobe.recGroup  = wGroup;
          strobe.recKind   = KIND_RISE;
          strobe.startPull = 1'b1;
          setPend          = 1'b1;
          nextState        = downOf(state);
        end else if (!faultLineIn) begin
          strobe.record   = 1'b1;
          strobe.recGroup = wGroup;
          strobe.recKind  = KIND_EXT;
          setPend         = 1'b1;
          nextState       = downOf(state);
        end else if (!onReq) begin
          nextState = downOf(state);
        end else if (wHigh) begin
          nextState = riseNext(state);
        end
      end
      ST_ON: begin
        if (!faultLineIn) begin
          strobe.record   = 1'b1;
          strobe.recGroup = 2'd3;
          strobe.recKind  = KIND_EXT;
          setPend         = 1'b1;
          nextState       = ST_DN3;
        end else if (!onReq) begin
          nextState = ST_DN3;
        end
      end
      ST_DN3, ST_DN2, ST_DN1: begin
        if (!faultLineIn && !pending) begin
          strobe.record   = 1'b1;
          strobe.recGroup = wGroup;
          strobe.recKind  = KIND_EXT;
          setPend         = 1'b1;
        end
        if (wLow || timeUp) begin
          if (!wLow) begin
            strobe.record    = 1'b1;
            strobe.recGroup  = wGroup;
            strobe.recKind   = KIND_FALL;
            strobe.startPull = 1'b1;
            setPend          = 1'b1;
          end
          if (state == ST_DN1) nextState = (pending || setPend) ? ST_FWAIT : ST_OFF;
          else                 nextState = fallNext(state);
        end
      end
      ST_FWAIT: begin
        if (retryDone && faultLineIn) begin
          clrPend   = 1'b1;
          nextState = onReq ? ST_UP1 : ST_OFF;
        end
      end
      default: nextState = ST_OFF;
    endcase
    strobe.clrTimer = (nextState != state);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_OFF;
      pending <= 1'b0;
    end else begin
      state <= nextState;
      if (setPend)      pending <= 1'b1;
      else if (clrPend) pending <= 1'b0;
    end
  end

  assign grpEnable = enableMask(state);
  assign powerGood = (state == ST_ON);

  // R2
  next_group_after_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grpEnable[1]) |-> $past(grpHigh[0]));
  // R2
  last_group_after_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grpEnable[2]) |-> $past(grpHigh[1]));
  // R3
  drain_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DN3 && grpLow[2]) |=> (state == ST_DN2));
  // R9
  off_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && !faultLineIn) |=> (grpEnable == 3'b000));
  // R4
  abort_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UP2 && !onReq && faultLineIn && !timeUp) |=> (state == ST_DN2));

endmodule

// File: rtl/railseq_datapath.sv
module railseq_datapath
  import railseq_pkg::*;
#(
  parameter int RETRY_CYC = 30,
  parameter int TIMER_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic               causeClear,
  output logic [TIMER_W-1:0] timer,
  output logic               pullActive,
  output logic               causeValid,
  output logic [1:0]         causeGroup,
  output logic [1:0]         causeKind
);

  logic [TIMER_W-1:0] pullCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobe.clrTimer) begin
      timer <= '0;
    end else if (timer != '1) begin
      timer <= timer + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pullCnt <= '0;
    end else if (strobe.startPull) begin
      pullCnt <= TIMER_W'(RETRY_CYC);
    end else if (pullCnt != '0) begin
      pullCnt <= pullCnt - 1'b1;
    end
  end

  assign pullActive = (pullCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeValid <= 1'b0;
      causeGroup <= 2'd0;
      causeKind  <= 2'd0;
    end else if (strobe.record) begin
      causeValid <= 1'b1;
      causeGroup <= strobe.recGroup;
      causeKind  <= strobe.recKind;
    end else if (causeClear) begin
      causeValid <= 1'b0;
      causeGroup <= 2'd0;
      causeKind  <= 2'd0;
    end
  end

  // R5
  pull_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startPull |=> pullActive);
  // R10
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.record && !causeClear) |=> $stable({causeValid, causeGroup, causeKind}));
  // R10
  cause_group_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    causeValid |-> (causeGroup != 2'd0 && causeKind != 2'd0));

endmodule

// File: rtl/railseq_top.sv
module railseq_top
  import railseq_pkg::*;
#(
  parameter int TIMEOUT_CYC = 40,
  parameter int RETRY_CYC   = 30
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       onReq,
  input  logic [2:0] grpHigh,
  input  logic [2:0] grpLow,
  input  logic       faultLineIn,
  input  logic       causeClear,
  output logic [2:0] grpEnable,
  output logic       powerGood,
  output logic       faultPullDown,
  output logic       causeValid,
  output logic [1:0] causeGroup,
  output logic [1:0] causeKind
);

  localparam int LONGEST = (TIMEOUT_CYC > RETRY_CYC) ? TIMEOUT_CYC : RETRY_CYC;
  localparam int TIMER_W = $clog2(LONGEST + 2);

  ctrlStrobe_t        strobe;
  seqState_t          state;
  logic [TIMER_W-1:0] timer;
  logic               pullActive;

  railseq_ctrl #(
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .RETRY_CYC  (RETRY_CYC),
    .TIMER_W    (TIMER_W)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .onReq      (onReq),
    .grpHigh    (grpHigh),
    .grpLow     (grpLow),
    .faultLineIn(faultLineIn),
    .timer      (timer),
    .strobe     (strobe),
    .state      (state),
    .grpEnable  (grpEnable),
    .powerGood  (powerGood)
  );

  railseq_datapath #(
    .RETRY_CYC(RETRY_CYC),
    .TIMER_W  (TIMER_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .causeClear(causeClear),
    .timer     (timer),
    .pullActive(pullActive),
    .causeValid(causeValid),
    .causeGroup(causeGroup),
    .causeKind (causeKind)
  );

  assign faultPullDown = pullActive;

  // R8
  retry_needs_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UP1 && $past(state) == ST_FWAIT) |-> ($past(faultLineIn) && !faultPullDown));
  // R5
  new_cause_has_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(causeValid) |-> (faultPullDown || $past(!faultLineIn)));
  // R7
  ext_no_pull_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_ON && state == ST_DN3 && causeKind == KIND_EXT && $rose(causeValid))
      |-> !faultPullDown);

endmodule

// File: tb/railseq_top_tb_top.sv
`timescale 1ns/1ps
module railseq_top_tb_top;

  localparam int TO = 40;
  localparam int RT = 30;
  localparam int NEVER = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic onReq = 1'b0;
  logic [2:0] grpHigh = 3'b000;
  logic [2:0] grpLow = 3'b111;
  logic extPull = 1'b0;
  logic causeClear = 1'b0;
  logic faultLineIn;
  logic [2:0] grpEnable;
  logic powerGood, faultPullDown, causeValid;
  logic [1:0] causeGroup, causeKind;

  assign faultLineIn = !(faultPullDown || extPull);

  always #2.5 clk = ~clk;

  railseq_top #(.TIMEOUT_CYC(TO), .RETRY_CYC(RT)) dut_i (
    .clk(clk), .rstN(rstN), .onReq(onReq), .grpHigh(grpHigh), .grpLow(grpLow),
    .faultLineIn(faultLineIn), .causeClear(causeClear), .grpEnable(grpEnable),
    .powerGood(powerGood), .faultPullDown(faultPullDown), .causeValid(causeValid),
    .causeGroup(causeGroup), .causeKind(causeKind)
  );

  int nChecks = 0;
  int nBad = 0;
  int cycles = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // rail plant: flags follow enables after per-group delays
  int riseDly[3] = '{3, 3, 3};
  int fallDly[3] = '{2, 2, 2};
  int upCnt[3]   = '{0, 0, 0};
  int dnCnt[3]   = '{NEVER, NEVER, NEVER};

  // behavioural model: mode + number of enabled groups
  localparam int M_IDLE = 0, M_RISE = 1, M_HOLD = 2, M_FALL = 3, M_WAIT = 4;
  int mode, lvl, tmr, pullLeft, cVal, cGrp, cKind;
  bit pend;

  always @(posedge clk) begin
    if (!rstN) begin
      mode = M_IDLE; lvl = 0; tmr = 0; pullLeft = 0; pend = 0;
      cVal = 0; cGrp = 0; cKind = 0;
    end else begin
      int nMode, nLvl, rg, rk, g;
      bit line, rec, load, nPend, adv, gh;
      line = !(pullLeft > 0 || extPull);
      nMode = mode; nLvl = lvl; rec = 0; load = 0; nPend = pend; adv = 0; rg = 0; rk = 0;
      case (mode)
        M_IDLE: if (onReq && line) begin nMode = M_RISE; nLvl = 1; end
        M_RISE: begin
          gh = grpHigh[lvl-1];
          if (tmr >= TO && !gh) begin
            rec = 1; rg = lvl; rk = 1; load = 1; nPend = 1; nMode = M_FALL; nLvl = lvl - 1;
          end else if (!line) begin
            rec = 1; rg = lvl; rk = 3; nPend = 1; nMode = M_FALL; nLvl = lvl - 1;
          end else if (!onReq) begin
            nMode = M_FALL; nLvl = lvl - 1;
          end else if (gh) begin
            if (lvl == 3) nMode = M_HOLD; else nLvl = lvl + 1;
          end
        end
        M_HOLD: begin
          if (!line) begin rec = 1; rg = 3; rk = 3; nPend = 1; nMode = M_FALL; nLvl = 2; end
          else if (!onReq) begin nMode = M_FALL; nLvl = 2; end
        end
        M_FALL: begin
          g = lvl + 1;
          if (!line && !pend) begin rec = 1; rg = g; rk = 3; nPend = 1; end
          if (grpLow[g-1]) adv = 1;
          else if (tmr >= TO) begin rec = 1; rg = g; rk = 2; load = 1; nPend = 1; adv = 1; end
          if (adv) begin
            if (lvl == 0) nMode = nPend ? M_WAIT : M_IDLE;
            else nLvl = lvl - 1;
          end
        end
        default: begin
          if (tmr >= RT && line) begin
            nPend = 0;
            if (onReq) begin nMode = M_RISE; nLvl = 1; end else nMode = M_IDLE;
          end
        end
      endcase
      if (nMode != mode || nLvl != lvl) tmr = 0; else tmr = tmr + 1;
      if (load) pullLeft = RT; else if (pullLeft > 0) pullLeft = pullLeft - 1;
      if (rec) begin cVal = 1; cGrp = rg; cKind = rk; end
      else if (causeClear) begin cVal = 0; cGrp = 0; cKind = 0; end
      mode = nMode; lvl = nLvl; pend = nPend;
    end
  end

  // compare every cycle, then move the plant
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(grpEnable == 3'((1 << lvl) - 1), "R2/R3 enables", grpEnable, (1 << lvl) - 1);
      check(powerGood == (mode == M_HOLD), "R2 powerGood", powerGood, mode == M_HOLD);
      check(faultPullDown == (pullLeft > 0), "R5/R6 pull", faultPullDown, pullLeft > 0);
      check(causeValid == cVal && causeGroup == cGrp && causeKind == cKind, "R10 cause",
            {causeValid, causeGroup, causeKind}, {cVal[0], cGrp[1:0], cKind[1:0]});
    end
    for (int i = 0; i < 3; i++) begin
      if (grpEnable[i]) begin
        dnCnt[i] = 0;
        if (upCnt[i] < NEVER) upCnt[i]++;
      end else begin
        upCnt[i] = 0;
        if (dnCnt[i] < NEVER) dnCnt[i]++;
      end
      grpHigh[i] = grpEnable[i] && upCnt[i] >= riseDly[i];
      grpLow[i]  = !grpEnable[i] && dnCnt[i] >= fallDly[i];
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      nChecks++; nBad++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitPg(input int cap, input string tag);
    int k = 0;
    while (!powerGood && k < cap) begin @(negedge clk); k++; end
    check(powerGood, tag, powerGood, 1);
  endtask

  task automatic waitCause(input int cap);
    int k = 0;
    while (!causeValid && k < cap) begin @(negedge clk); k++; end
  endtask

  task automatic pulseClear();
    causeClear = 1'b1;
    @(negedge clk);
    causeClear = 1'b0;
  endtask

  initial begin
    waitCyc(3);
    check(grpEnable == 0 && !powerGood && !faultPullDown && !causeValid, "R1 in reset",
          {grpEnable, powerGood, faultPullDown, causeValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(grpEnable == 0 && !causeValid && !faultPullDown, "R1 after reset", grpEnable, 0);

    // normal up and down with uneven delays
    riseDly = '{3, 5, 4}; fallDly = '{6, 2, 3};
    onReq = 1'b1;
    @(negedge clk);
    check(grpEnable == 3'b001, "R2 group1 first", grpEnable, 1);
    waitPg(100, "R2 reached on");
    check(grpEnable == 3'b111, "R2 all enabled", grpEnable, 7);
    onReq = 1'b0;
    @(negedge clk);
    check(grpEnable == 3'b011, "R3 group3 released first", grpEnable, 3);
    waitCyc(40);
    check(grpEnable == 0 && !causeValid, "R3 back off no fault", grpEnable, 0);

    // request dropped while group 2 is rising
    riseDly = '{3, NEVER, 3};
    onReq = 1'b1;
    waitCyc(10);
    check(grpEnable == 3'b011, "R4 waiting in group2", grpEnable, 3);
    onReq = 1'b0;
    @(negedge clk);
    check(grpEnable == 3'b001, "R4 group2 released at once", grpEnable, 1);
    waitCyc(30);
    check(grpEnable == 0 && !causeValid && !faultPullDown, "R4 no fault", causeValid, 0);

    // group 3 never rises: rise timeout, pull, retry
    riseDly = '{3, 3, NEVER};
    onReq = 1'b1;
    waitCause(200);
    check(causeGroup == 2'd3 && causeKind == 2'd1, "R5 rise timeout cause",
          {causeGroup, causeKind}, {2'd3, 2'd1});
    check(faultPullDown, "R5 line pulled", faultPullDown, 1);
    begin
      int k = 0;
      while (grpEnable != 3'b001 && k < 400) begin @(negedge clk); k++; end
      check(grpEnable == 3'b001, "R8 retry restarted", grpEnable, 1);
    end
    check(causeValid && causeGroup == 2'd3, "R10 cause kept across retry", causeGroup, 3);
    onReq = 1'b0;
    waitCyc(30);
    pulseClear();
    @(negedge clk);
    check(!causeValid && causeGroup == 0 && causeKind == 0, "R10 cleared", causeValid, 0);
    waitCyc(120);

    // group 2 never drains: fall timeout
    riseDly = '{3, 3, 3};
    onReq = 1'b1;
    waitPg(100, "R2 on again");
    fallDly = '{2, NEVER, 2};
    onReq = 1'b0;
    waitCause(200);
    check(causeGroup == 2'd2 && causeKind == 2'd2 && faultPullDown, "R6 fall timeout",
          {causeGroup, causeKind, faultPullDown}, {2'd2, 2'd2, 1'b1});
    @(negedge clk);
    check(grpEnable == 3'b000, "R6 descent continued", grpEnable, 0);
    fallDly = '{2, 2, 2};
    waitCyc(120);
    check(grpEnable == 0 && !powerGood, "R8 idle after wait", grpEnable, 0);
    pulseClear();

    // external fault while on
    onReq = 1'b1;
    waitPg(100, "R2 on for ext");
    extPull = 1'b1;
    @(negedge clk);
    check(causeValid && causeGroup == 2'd3 && causeKind == 2'd3, "R7 external cause",
          {causeGroup, causeKind}, {2'd3, 2'd3});
    check(!faultPullDown, "R7 no self pull", faultPullDown, 0);
    waitCyc(150);
    check(grpEnable == 0, "R8 held while line low", grpEnable, 0);
    extPull = 1'b0;
    waitPg(200, "R8 retry after release");
    onReq = 1'b0;
    waitCyc(40);
    pulseClear();

    // start blocked by low line in off
    extPull = 1'b1;
    onReq = 1'b1;
    waitCyc(20);
    check(grpEnable == 0 && !causeValid, "R9 off blocked", grpEnable, 0);
    extPull = 1'b0;
    waitCyc(2);
    check(grpEnable == 3'b001, "R9 starts after release", grpEnable, 1);
    waitPg(100, "R2 final on");
    onReq = 1'b0;
    waitCyc(40);
    check(grpEnable == 0, "R3 final off", grpEnable, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule